// File: doc/BRIEF.md
# Security-Region Erase Controller for a Serial Flash

This block is the device-side command logic of a serial flash that can erase any one of three small security regions. Each region can be write-protected for good by a sticky lock bit. A host drives an SPI link in mode 0 or mode 3. Every bit is taken on a rising serial-clock edge while chip select is low. The block assembles an 8-bit opcode and, for an erase, a 24-bit address, most significant bit first. It then decides at the rising edge of chip select whether the command takes effect.

An erase needs four things: the write-enable latch must be set, the address must name a valid, unlocked region, and chip select must rise after exactly 32 bits. When all hold, a self-timed erase runs for a set number of system clocks. During the erase a busy flag reads high and a status read still works. At the end, the region's erased flag is set, which stands for the whole region reading 0xFF, and the write-enable latch is cleared. Array storage and every other command are out of scope.

The serial pins are sampled into the system clock domain, so the serial clock must run well below the system clock.

Top module: `sec_erase_ctl`

## Requirements
- R1: After reset, busy, wel_out, region_erased, region_locked and spi_miso are all 0.
- R2: A frame with opcode 0x06 and chip select rising after exactly 8 bits sets wel_out to 1, unless busy is 1.
- R3: Opcode 0x05 shifts out a status byte on spi_miso, MSB first, one bit per falling serial-clock edge after the opcode. Bit 0 is busy, bit 1 is the write-enable latch and bits 7..2 are 0. The byte repeats while chip select stays low.
- R4: A frame of opcode 0x44 plus a 24-bit address starts an erase when four conditions hold: the latch is 1, the region is valid and unlocked, chip select rises after exactly 32 bits, and the block is not busy. busy then stays 1 for ERASE_CYCLES system clocks and returns to 0.
- R5: When an erase ends, region_erased bit (region-1) becomes 1 and wel_out becomes 0, on the same clock edge on which busy falls.
- R6: An erase frame received while wel_out is 0 is ignored.
- R7: A frame whose chip-select rise comes after any bit count other than its command length (8 for 0x06, 32 for 0x44) is discarded, with no change to wel_out.
- R8: Address bits 15..12 select the region (1, 2 or 3). Bits 23..16 and 11..8 must be 0, and bits 7..0 are ignored. Any other address is ignored, and wel_out is left unchanged.
- R9: A pulse on lock_set bit i sets region_locked bit i, which never clears. An erase aimed at a locked region is ignored, and wel_out stays 1.
- R10: While busy is 1, status reads are served, but the write-enable and erase opcodes have no effect.
- R11: Opcodes other than 0x06, 0x05 and 0x44 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock (mode 0 or 3) |
| spi_csn | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial status data out |
| lock_set | input | 3 | One-clock pulses that permanently lock regions 1..3 |
| busy | output | 1 | Erase in progress |
| wel_out | output | 1 | Write-enable latch |
| region_locked | output | 3 | Sticky lock bits, one per region |
| region_erased | output | 3 | Set when the matching region has been erased |

## Verification
The assertions assume that reset is held low for several system clocks before the first frame. They also assume that every serial-clock level lasts at least SYNC_STAGES+1 system clocks, so that no pin edge is lost in sampling. The bench holds each serial-clock phase for four system clocks. It opens and closes every frame with chip select at least four clocks away from any serial-clock edge. It pulses lock_set for one clock only, between frames. Random frames draw opcodes, region fields, illegal address bits and truncated or overlong bit counts. They run in both clock modes and stay inside these timing rules.

// File: rtl/sec_erase_pkg.sv
package sec_erase_pkg;
   localparam int OPC_W      = 8;
   localparam int ADR_W      = 24;
   localparam int FRAME_BITS = OPC_W + ADR_W;
   localparam int NUM_REG    = 3;

   localparam logic [OPC_W-1:0] OPC_WREN  = 8'h06;
   localparam logic [OPC_W-1:0] OPC_RDST  = 8'h05;
   localparam logic [OPC_W-1:0] OPC_ERASE = 8'h44;

   // returns 1..3 for a valid region, 0 when the address names none
   function automatic logic [1:0] region_of(input logic [ADR_W-1:0] a);
      logic [1:0] r;
      r = 2'd0;
      if (a[23:16] == 8'h00 && a[11:8] == 4'h0) begin
         case (a[15:12])
            4'h1: r = 2'd1;
            4'h2: r = 2'd2;
            4'h3: r = 2'd3;
            default: r = 2'd0;
         endcase
      end
      return r;
   endfunction
endpackage

// File: rtl/spi_pin_sampler.sv
module spi_pin_sampler #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sck,
   input  logic csn,
   input  logic mosi,
   output logic sck_rise,
   output logic sck_fall,
   output logic cs_rise,
   output logic cs_active,
   output logic mosi_s
);
   // stage word layout: {sck, csn, mosi}
   localparam logic [2:0] IDLE = 3'b010;

   logic [2:0] stage [SYNC_STAGES];
   logic [2:0] prev;
   logic [2:0] cur;

   if (SYNC_STAGES < 1 || SYNC_STAGES > 4) begin : g_chk
      $error("SYNC_STAGES must be 1..4");
   end

   for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) stage[g] <= IDLE;
            else        stage[g] <= {sck, csn, mosi};
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) stage[g] <= IDLE;
            else        stage[g] <= stage[g-1];
      end
   end

   assign cur = stage[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) prev <= IDLE;
      else        prev <= cur;

   assign cs_active = ~cur[1];
   assign sck_rise  =  cur[2] & ~prev[2] & ~cur[1];
   assign sck_fall  = ~cur[2] &  prev[2] & ~cur[1];
   assign cs_rise   =  cur[1] & ~prev[1];
   assign mosi_s    =  cur[0];
endmodule

// File: rtl/spi_cmd_shift.sv
module spi_cmd_shift
   import sec_erase_pkg::*;
#(
   parameter int CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cs_active,
   input  logic             sck_rise,
   input  logic             mosi_s,
   output logic [OPC_W-1:0] opcode,
   output logic [ADR_W-1:0] addr,
   output logic [CNT_W-1:0] bit_cnt
);
   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FRAME_BITS + 1);

   if ((1 << CNT_W) <= FRAME_BITS + 1) begin : g_chk
      $error("CNT_W too small for the frame length");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         opcode  <= '0;
         addr    <= '0;
         bit_cnt <= '0;
      end else if (!cs_active) begin
         bit_cnt <= '0;
      end else if (sck_rise) begin
         if (bit_cnt < CNT_W'(OPC_W))
            opcode <= {opcode[OPC_W-2:0], mosi_s};
         else if (bit_cnt < CNT_W'(FRAME_BITS))
            addr <= {addr[ADR_W-2:0], mosi_s};
         if (bit_cnt != CNT_MAX)
            bit_cnt <= bit_cnt + 1'b1;
      end
   end
endmodule

// File: rtl/erase_timer.sv
module erase_timer #(
   parameter int ERASE_CYCLES = 64
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic [1:0] region_in,
   output logic       busy,
   output logic       done,
   output logic [1:0] region_q
);
   localparam int TW = $clog2(ERASE_CYCLES + 1);

   logic [TW-1:0] remain;

   if (ERASE_CYCLES < 2) begin : g_chk
      $error("ERASE_CYCLES must be at least 2");
   end

   assign done = busy && (remain == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         remain   <= '0;
         region_q <= 2'd0;
      end else if (start && !busy) begin
         busy     <= 1'b1;
         remain   <= TW'(ERASE_CYCLES - 1);
         region_q <= region_in;
      end else if (busy) begin
         if (done) busy   <= 1'b0;
         else      remain <= remain - 1'b1;
      end
   end
endmodule

// File: rtl/sec_erase_ctl.sv
module sec_erase_ctl
   import sec_erase_pkg::*;
#(
   parameter int ERASE_CYCLES = 64,
   parameter int SYNC_STAGES  = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       spi_sck,
   input  logic       spi_csn,
   input  logic       spi_mosi,
   output logic       spi_miso,
   input  logic [2:0] lock_set,
   output logic       busy,
   output logic       wel_out,
   output logic [2:0] region_locked,
   output logic [2:0] region_erased
);
   localparam int CNT_W = $clog2(FRAME_BITS + 2);

   logic             sck_rise, sck_fall, cs_rise, cs_active, mosi_s;
   logic [OPC_W-1:0] opcode;
   logic [ADR_W-1:0] addr;
   logic [CNT_W-1:0] bit_cnt;
   logic [1:0]       region, done_region;
   logic             region_ok, start, done, wel;
   logic [2:0]       out_idx;
   logic [7:0]       status;

   spi_pin_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_pins (
      .clk(clk), .rst_n(rst_n), .sck(spi_sck), .csn(spi_csn), .mosi(spi_mosi),
      .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_rise(cs_rise),
      .cs_active(cs_active), .mosi_s(mosi_s));

   spi_cmd_shift #(.CNT_W(CNT_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .cs_active(cs_active), .sck_rise(sck_rise),
      .mosi_s(mosi_s), .opcode(opcode), .addr(addr), .bit_cnt(bit_cnt));

   erase_timer #(.ERASE_CYCLES(ERASE_CYCLES)) u_timer (
      .clk(clk), .rst_n(rst_n), .start(start), .region_in(region),
      .busy(busy), .done(done), .region_q(done_region));

   assign region    = region_of(addr);
   assign region_ok = (region != 2'd0) && !region_locked[region - 2'd1];
   assign start     = cs_rise && !busy && wel && region_ok
                      && opcode == OPC_ERASE && bit_cnt == CNT_W'(FRAME_BITS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                    wel <= 1'b0;
      else if (done)                                 wel <= 1'b0;
      else if (cs_rise && !busy && opcode == OPC_WREN
               && bit_cnt == CNT_W'(OPC_W))          wel <= 1'b1;
   end
   assign wel_out = wel;

   for (genvar g = 0; g < NUM_REG; g++) begin : g_region
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            region_locked[g] <= 1'b0;
            region_erased[g] <= 1'b0;
         end else begin
            if (lock_set[g]) region_locked[g] <= 1'b1;
            if (done && done_region == 2'(g + 1)) region_erased[g] <= 1'b1;
         end
      end
   end

   // status byte out on falling serial-clock edges
   assign status = {6'b0, wel, busy};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         spi_miso <= 1'b0;
         out_idx  <= 3'd0;
      end else if (!cs_active) begin
         spi_miso <= 1'b0;
         out_idx  <= 3'd0;
      end else if (sck_fall && opcode == OPC_RDST && bit_cnt >= CNT_W'(OPC_W)) begin
         spi_miso <= status[3'd7 - out_idx];
         out_idx  <= out_idx + 1'b1;
      end
   end
endmodule

// File: rtl/sec_erase_ctl_chk.sv
module sec_erase_ctl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       busy,
   input logic       wel_out,
   input logic [2:0] region_locked,
   input logic [2:0] region_erased
);
   // R4: an erase only begins with the latch set
   a_r4_start_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(wel_out));

   // R5: the latch is clear once the erase finishes
   a_r5_wel_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> !wel_out);

   // R5: erased flags move only as an erase ends
   a_r5_erased_at_end: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(region_erased) |-> $fell(busy));

   // R9: lock bits are sticky
   a_r9_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(region_locked) & ~region_locked) == 3'b000));

   // R10: the latch cannot be set while busy
   a_r10_no_wel_busy: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wel_out) |-> !$past(busy));

   // R5: erased flags never clear
   a_r5_erased_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(region_erased) & ~region_erased) == 3'b000));
endmodule

bind sec_erase_ctl sec_erase_ctl_chk u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .wel_out(wel_out),
   .region_locked(region_locked), .region_erased(region_erased));

// File: tb/tb_sec_erase_ctl.sv
module tb_sec_erase_ctl;
   localparam int ERASE_CYCLES = 600;
   localparam int HP = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sck = 1'b0, csn = 1'b1, mosi = 1'b0;
   logic miso, busy, wel;
   logic [2:0] lock_set = 3'b000;
   logic [2:0] locked, erased;

   int checks = 0;
   int errors = 0;

   // model state
   logic       m_wel = 1'b0;
   logic [2:0] m_lock = 3'b000;
   logic [2:0] m_er = 3'b000;

   sec_erase_ctl #(.ERASE_CYCLES(ERASE_CYCLES)) dut (
      .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_csn(csn), .spi_mosi(mosi),
      .spi_miso(miso), .lock_set(lock_set), .busy(busy), .wel_out(wel),
      .region_locked(locked), .region_erased(erased));

   always #2 clk = ~clk;

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [1:0] exp_region(input logic [23:0] a);
      if (a[23:16] != 0 || a[11:8] != 0) return 2'd0;
      if (a[15:12] >= 1 && a[15:12] <= 3) return a[13:12];
      return 2'd0;
   endfunction

   // one frame of nbits from {op,addr}, MSB first
   task automatic frame(input logic [7:0] op, input logic [23:0] a,
                        input int nbits, input bit mode3);
      logic [31:0] w;
      w = {op, a};
      sck = mode3;
      tick(HP);
      csn = 1'b0;
      tick(HP);
      for (int i = 0; i < nbits; i++) begin
         sck = 1'b0;
         mosi = (i < 32) ? w[31-i] : 1'b0;
         tick(HP);
         sck = 1'b1;
         tick(HP);
         if (!mode3) sck = 1'b0;
      end
      tick(HP);
      csn = 1'b1;
      tick(8);
   endtask

   task automatic read_status(output logic [7:0] v);
      sck = 1'b0;
      csn = 1'b0;
      tick(HP);
      for (int i = 0; i < 8; i++) begin
         mosi = (8'h05 >> (7 - i)) & 1'b1;
         tick(HP);
         sck = 1'b1;
         tick(HP);
         sck = 1'b0;
      end
      for (int i = 0; i < 8; i++) begin
         tick(HP);
         v[7-i] = miso;
         sck = 1'b1;
         tick(HP);
         sck = 1'b0;
      end
      tick(HP);
      csn = 1'b1;
      tick(8);
   endtask

   task automatic check_state(input string tag);
      chk(wel, m_wel, {tag, " wel"});
      chk(erased, m_er, {tag, " erased"});
      chk(locked, m_lock, {tag, " locked"});
      chk(busy, 0, {tag, " busy"});
   endtask

   // issues an erase frame and follows the model
   task automatic do_erase(input logic [23:0] a, input int nbits, input bit mode3);
      logic [1:0] r;
      bit go;
      r = exp_region(a);
      go = m_wel && nbits == 32 && r != 0 && !m_lock[r-1];
      frame(8'h44, a, nbits, mode3);
      if (go) begin
         tick(10);
         chk(busy, 1, "R4 busy during erase");
         tick(ERASE_CYCLES);
         chk(busy, 0, "R4 busy ends");
         m_er[r-1] = 1'b1;
         m_wel = 1'b0;
         check_state("R5 after erase");
      end else begin
         tick(4);
         check_state("R6/R7/R8/R9 ignored erase");
      end
   endtask

   task automatic do_wren(input int nbits, input bit mode3);
      frame(8'h06, 24'h0, nbits, mode3);
      if (nbits == 8) m_wel = 1'b1;
      check_state(nbits == 8 ? "R2 wren" : "R7 short wren");
   endtask

   task automatic do_lock(input logic [2:0] m);
      lock_set = m;
      tick(1);
      lock_set = 3'b000;
      tick(2);
      m_lock |= m;
      check_state("R9 lock");
   endtask

   initial begin
      repeat (300000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] st;
      void'($urandom(32'd1234));
      tick(5);
      // R1 reset state, sampled while still in reset and after release
      chk({busy, wel, erased, locked, miso}, 0, "R1 reset state");
      rst_n = 1'b1;
      tick(5);
      check_state("R1 after release");

      // R3 idle status read
      read_status(st);
      chk(st, 8'h00, "R3 status idle");
      // R6 erase without latch
      do_erase(24'h001000, 32, 1'b0);
      // R2 then R3 status shows wel
      do_wren(8, 1'b0);
      read_status(st);
      chk(st, 8'h02, "R3 status wel");
      // R7 one bit too many and one too few
      do_erase(24'h002000, 33, 1'b0);
      do_erase(24'h002000, 31, 1'b1);
      // R8 bad addresses
      do_erase(24'h004000, 32, 1'b0);
      do_erase(24'h000000, 32, 1'b0);
      do_erase(24'h011000, 32, 1'b0);
      do_erase(24'h001100, 32, 1'b0);
      // R11 unknown opcode
      frame(8'hA5, 24'h0, 8, 1'b0);
      check_state("R11 unknown opcode");
      // R4/R5 valid erase, low bits don't care, mode 3
      do_erase(24'h0020FF, 32, 1'b1);
      // R10 busy: status read shows busy, wren ignored
      do_wren(8, 1'b0);
      frame(8'h44, 24'h003000, 32, 1'b0);
      tick(10);
      read_status(st);
      chk(st, 8'h03, "R10 status busy");
      frame(8'h06, 24'h0, 8, 1'b0);
      chk(wel, 1, "R10 wel held");
      frame(8'h44, 24'h001000, 32, 1'b0);
      tick(ERASE_CYCLES);
      m_er[2] = 1'b1;
      m_wel = 1'b0;
      check_state("R10 only first erase ran");
      // R9 locked region ignored
      do_lock(3'b001);
      do_wren(8, 1'b1);
      do_erase(24'h001000, 32, 1'b0);
      chk(wel, 1, "R9 wel kept");

      // random phase
      for (int it = 0; it < 60; it++) begin
         int kind;
         logic [23:0] a;
         bit m3;
         kind = $urandom_range(0, 5);
         m3 = $urandom_range(0, 1);
         a = {(($urandom_range(0, 7) == 0) ? 8'h01 : 8'h00),
              4'($urandom_range(0, 4)),
              (($urandom_range(0, 7) == 0) ? 4'h2 : 4'h0),
              8'($urandom)};
         case (kind)
            0, 1: do_wren(($urandom_range(0, 3) == 0) ? 9 : 8, m3);
            2, 3: do_erase(a, ($urandom_range(0, 4) == 0) ? 24 : 32, m3);
            4: do_lock(3'($urandom_range(0, 7)) & 3'b110);
            default: begin
               read_status(st);
               chk(st, {6'b0, m_wel, 1'b0}, "R3 random status");
            end
         endcase
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule